// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block performs the address decoding and bank selection for a game-console cartridge. On the CPU side it handles the upper 32 KB of the 16-bit address space. The lower 16 KB of that range is a window onto a switchable 16 KB bank of program ROM. The upper 16 KB is permanently tied to the final bank, where reset and interrupt code normally lives. The mapper has no data path of its own. It produces the ROM address and a hit flag, and the ROM sits outside the block.

Every CPU write into the ROM range is a register write. If address bits [15:12] equal 0x9, the write picks a single-screen nametable page. From then on that choice replaces the mirroring wired on the board. Any other write in the ROM range loads the whole byte into the bank register. Only the low bits of that register are used, which wraps an oversized bank number into the banks that exist. On the video side, the bottom 8 KB passes straight through to a character RAM with no banking.

Top module: `cart_mapper`

## Requirements
- R1: After reset the bank register is 0, so a read of 0x8123 gives ROM address 0x00123. The mirroring output then follows the board mirroring input, which uses the code 0 horizontal, 1 vertical, 2 single-screen page 0, 3 single-screen page 1.
- R2: A CPU read in 0x8000–0xBFFF gives `cpu_rd_hit`=1 and a ROM address of {bank, address[13:0]}.
- R3: A CPU read in 0xC000–0xFFFF gives a ROM address of {PRG_BANKS−1, address[13:0]}, whatever the bank register holds.
- R4: The bank number used for the switchable window is the bank register modulo PRG_BANKS. With 8 banks, a written value of 0x0B selects bank 3.
- R5: A CPU write with address[15:12]=0x9 sets the mirroring output from the next clock edge: code 3 if data bit 4 is 1, code 2 if it is 0. The bank register does not change.
- R6: A CPU write anywhere else in 0x8000–0xFFFF loads the full data byte into the bank register on the next clock edge. The mirroring output does not change.
- R7: Once a mirroring write has taken place, changes on the board mirroring input have no effect on the mirroring output.
- R8: A video-side access in 0x0000–0x1FFF gives `ppu_hit`=1 and a CHR RAM address equal to address[12:0]. A write also raises `chr_we`.
- R9: CPU accesses below 0x8000 and video accesses at 0x2000 and above raise no hit, no write acknowledge and no CHR write strobe, and they leave the bank register and mirroring unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| board_mirror | input | 2 | Mirroring wired on the board |
| prg_addr | output | 17 | Program ROM byte address (BANK_W+14 bits) |
| cpu_rd_hit | output | 1 | CPU read falls in the ROM range |
| cpu_wr_ack | output | 1 | CPU write accepted as a register write |
| ppu_addr | input | 14 | Video-side address |
| ppu_rd | input | 1 | Video read strobe |
| ppu_wr | input | 1 | Video write strobe |
| chr_addr | output | 13 | CHR RAM address |
| chr_we | output | 1 | CHR RAM write enable |
| ppu_hit | output | 1 | Video access falls in CHR space |
| mirror_out | output | 2 | Nametable mirroring code |

## Verification
The hardest state to reach is the hand-over from board-wired mirroring to mapper-selected mirroring. Before the first write to the 0x9xxx range, the output must follow the board input. After that write it must ignore the board input completely. The bench first toggles the board input and checks that the output follows it. It then makes a mirroring write and toggles the board input through every code, checking that the output holds. Writes to 0x9xxx are interleaved with bank writes to 0xF000 and 0x8000, to show that neither kind of write disturbs the other register.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;
  localparam int CPU_AW  = 16;
  localparam int DATA_W  = 8;
  localparam int WIN_AW  = 14;
  localparam int PPU_AW  = 14;
  localparam int CHR_AW  = 13;
  localparam logic [3:0] MIRROR_NIBBLE = 4'h9;

  typedef enum logic [1:0] {
    MIR_HORZ   = 2'd0,
    MIR_VERT   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;
endpackage

// File: rtl/cart_mapper_rst_sync.sv
module cart_mapper_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cart_mapper_cpu_dec.sv
module cart_mapper_cpu_dec
  import cart_mapper_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [DATA_W-1:0]        bank_q,
  output logic [BANK_W+WIN_AW-1:0] prg_addr,
  output logic                     cpu_rd_hit,
  output logic                     cpu_wr_ack,
  output logic                     bank_wr,
  output logic                     mirror_wr
);
  logic              in_rom;
  logic              fixed_win;
  logic [BANK_W-1:0] bank_sel;

  always_comb begin
    in_rom    = cpu_addr[CPU_AW-1];
    fixed_win = cpu_addr[CPU_AW-2];
    // power-of-two bank count: modulo is the low bits
    bank_sel  = fixed_win ? {BANK_W{1'b1}} : bank_q[BANK_W-1:0];
    prg_addr  = {bank_sel, cpu_addr[WIN_AW-1:0]};
    cpu_rd_hit = cpu_rd & in_rom;
    cpu_wr_ack = cpu_wr & in_rom;
    mirror_wr  = cpu_wr_ack & (cpu_addr[CPU_AW-1:CPU_AW-4] == MIRROR_NIBBLE);
    bank_wr    = cpu_wr_ack & ~mirror_wr;
  end
endmodule

// File: rtl/cart_mapper_regs.sv
module cart_mapper_regs
  import cart_mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic              mirror_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        board_mirror,
  output logic [DATA_W-1:0] bank_q,
  output logic              mirror_lock,
  output logic [1:0]        mirror_out
);
  logic [DATA_W-1:0] bank_d;
  mirror_e           mir_q, mir_d;
  logic              lock_d;

  always_comb begin
    bank_d = wdata;
    mir_d  = wdata[4] ? MIR_ONE_HI : MIR_ONE_LO;
    lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_wr) bank_q <= bank_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mir_q       <= MIR_HORZ;
      mirror_lock <= 1'b0;
    end else if (mirror_wr) begin
      mir_q       <= mir_d;
      mirror_lock <= lock_d;
    end
  end

  assign mirror_out = mirror_lock ? mir_q : board_mirror;
endmodule

// File: rtl/cart_mapper_ppu_dec.sv
module cart_mapper_ppu_dec
  import cart_mapper_pkg::*;
(
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              ppu_rd,
  input  logic              ppu_wr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_we,
  output logic              ppu_hit
);
  logic in_chr;

  always_comb begin
    in_chr   = ~ppu_addr[PPU_AW-1];
    chr_addr = ppu_addr[CHR_AW-1:0];
    chr_we   = ppu_wr & in_chr;
    ppu_hit  = (ppu_rd | ppu_wr) & in_chr;
  end
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_mapper_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  localparam int BANK_W   = $clog2(PRG_BANKS),
  localparam int PRG_AW   = BANK_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [1:0]        board_mirror,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              cpu_rd_hit,
  output logic              cpu_wr_ack,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_rd,
  input  logic              ppu_wr,
  output logic [12:0]       chr_addr,
  output logic              chr_we,
  output logic              ppu_hit,
  output logic [1:0]        mirror_out
);
  logic              rst_n_sync;
  logic [DATA_W-1:0] bank_q;
  logic              bank_wr;
  logic              mirror_wr;
  logic              mirror_lock;

  cart_mapper_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cart_mapper_cpu_dec #(.BANK_W(BANK_W)) u_cpu (
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .bank_q     (bank_q),
    .prg_addr   (prg_addr),
    .cpu_rd_hit (cpu_rd_hit),
    .cpu_wr_ack (cpu_wr_ack),
    .bank_wr    (bank_wr),
    .mirror_wr  (mirror_wr)
  );

  cart_mapper_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .bank_wr      (bank_wr),
    .mirror_wr    (mirror_wr),
    .wdata        (cpu_wdata),
    .board_mirror (board_mirror),
    .bank_q       (bank_q),
    .mirror_lock  (mirror_lock),
    .mirror_out   (mirror_out)
  );

  cart_mapper_ppu_dec u_ppu (
    .ppu_addr (ppu_addr),
    .ppu_rd   (ppu_rd),
    .ppu_wr   (ppu_wr),
    .chr_addr (chr_addr),
    .chr_we   (chr_we),
    .ppu_hit  (ppu_hit)
  );
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk #(
  parameter int PRG_AW = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_wr,
  input logic [PRG_AW-1:0] prg_addr,
  input logic              cpu_wr_ack,
  input logic [13:0]       ppu_addr,
  input logic              chr_we,
  input logic [7:0]        bank_q,
  input logic              mirror_lock,
  input logic [1:0]        mirror_out
);
  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11) |-> (&prg_addr[PRG_AW-1:14])); // R3

  AST_MIRROR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h9) |=>
      (mirror_out == ($past(cpu_wdata[4]) ? 2'd3 : 2'd2)) && $stable(bank_q)); // R5

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && cpu_addr[15:12] != 4'h9) |=>
      (bank_q == $past(cpu_wdata))); // R6

  AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_lock && !(cpu_wr && cpu_addr[15:12] == 4'h9)) |=> $stable(mirror_out)); // R7

  AST_LOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |=> ($stable(bank_q) && $stable(mirror_lock))); // R9

  AST_NO_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> !cpu_wr_ack); // R9

  AST_CHR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we |-> !ppu_addr[13]); // R8
endmodule

bind cart_mapper cart_mapper_chk #(.PRG_AW(PRG_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .cpu_wr      (cpu_wr),
  .prg_addr    (prg_addr),
  .cpu_wr_ack  (cpu_wr_ack),
  .ppu_addr    (ppu_addr),
  .chr_we      (chr_we),
  .bank_q      (bank_q),
  .mirror_lock (mirror_lock),
  .mirror_out  (mirror_out)
);

// File: tb/cart_mapper_tb.sv
module cart_mapper_tb;
  localparam int PRG_AW = 17;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       cpu_addr;
  logic [7:0]        cpu_wdata;
  logic              cpu_rd, cpu_wr;
  logic [1:0]        board_mirror;
  logic [PRG_AW-1:0] prg_addr;
  logic              cpu_rd_hit, cpu_wr_ack;
  logic [13:0]       ppu_addr;
  logic              ppu_rd, ppu_wr;
  logic [12:0]       chr_addr;
  logic              chr_we, ppu_hit;
  logic [1:0]        mirror_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cart_mapper #(.PRG_BANKS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .board_mirror(board_mirror),
    .prg_addr(prg_addr), .cpu_rd_hit(cpu_rd_hit), .cpu_wr_ack(cpu_wr_ack),
    .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
    .chr_addr(chr_addr), .chr_we(chr_we), .ppu_hit(ppu_hit),
    .mirror_out(mirror_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
  endtask

  task automatic cpu_read(input string req, input logic [15:0] a, input logic [PRG_AW-1:0] exp);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1;
    check(req, {31'd0, cpu_rd_hit}, 32'd1);
    check(req, {15'd0, prg_addr}, {15'd0, exp});
    cpu_rd = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 mirror follows board", {30'd0, mirror_out}, 32'd1);
    cpu_read("R1 bank zero", 16'h8123, 17'h00123);
    board_mirror = 2'd0; #1;
    check("R1 mirror follows board change", {30'd0, mirror_out}, 32'd0);
  endtask

  task automatic t_windows();
    cpu_write(16'hA000, 8'h05);
    cpu_read("R6 bank load", 16'h8000, 17'h14000);
    cpu_read("R2 lower window", 16'hBFFF, 17'h17FFF);
    cpu_read("R3 fixed low end", 16'hC000, 17'h1C000);
    cpu_read("R3 fixed high end", 16'hFFFF, 17'h1FFFF);
    cpu_write(16'hF000, 8'h02);
    cpu_read("R6 bank via F000", 16'h8010, 17'h08010);
    check("R6 mirror untouched", {30'd0, mirror_out}, 32'd0);
  endtask

  task automatic t_wrap();
    cpu_write(16'h8000, 8'h0B);
    cpu_read("R4 wrap 0x0B", 16'h8005, 17'h0C005);
    cpu_write(16'hC000, 8'hFF);
    cpu_read("R4 wrap 0xFF", 16'h8001, 17'h1C001);
    cpu_write(16'hB000, 8'h00);
  endtask

  task automatic t_mirror();
    cpu_write(16'h9ABC, 8'h10);
    check("R5 page1", {30'd0, mirror_out}, 32'd3);
    cpu_read("R5 bank kept", 16'h8002, 17'h00002);
    board_mirror = 2'd1; #1;
    check("R7 board ignored", {30'd0, mirror_out}, 32'd3);
    cpu_write(16'h9000, 8'hEF);
    check("R5 page0", {30'd0, mirror_out}, 32'd2);
    cpu_read("R5 bank kept", 16'h8003, 17'h00003);
    for (int m = 0; m < 4; m++) begin
      board_mirror = m[1:0]; #1;
      check("R7 board ignored", {30'd0, mirror_out}, 32'd2);
    end
  endtask

  task automatic t_outside();
    @(negedge clk);
    cpu_addr = 16'h1000; cpu_wdata = 8'h06; cpu_wr = 1'b1; #1;
    check("R9 no ack low", {31'd0, cpu_wr_ack}, 32'd0);
    @(negedge clk);
    cpu_addr = 16'h1900; cpu_wdata = 8'h10; #1;
    check("R9 no ack low", {31'd0, cpu_wr_ack}, 32'd0);
    @(negedge clk);
    cpu_wr = 1'b0;
    cpu_addr = 16'h7FFF; cpu_rd = 1'b1; #1;
    check("R9 no read hit", {31'd0, cpu_rd_hit}, 32'd0);
    cpu_rd = 1'b0;
    cpu_read("R9 bank unchanged", 16'h8004, 17'h00004);
    check("R9 mirror unchanged", {30'd0, mirror_out}, 32'd2);
  endtask

  task automatic t_chr();
    @(negedge clk);
    ppu_addr = 14'h1ABC; ppu_wr = 1'b1; #1;
    check("R8 chr we", {31'd0, chr_we}, 32'd1);
    check("R8 chr addr", {19'd0, chr_addr}, 32'h1ABC);
    check("R8 ppu hit", {31'd0, ppu_hit}, 32'd1);
    ppu_wr = 1'b0; ppu_rd = 1'b1; ppu_addr = 14'h0000; #1;
    check("R8 read hit", {31'd0, ppu_hit}, 32'd1);
    check("R8 read no we", {31'd0, chr_we}, 32'd0);
    ppu_addr = 14'h2000; #1;
    check("R9 ppu no hit", {31'd0, ppu_hit}, 32'd0);
    ppu_rd = 1'b0; ppu_wr = 1'b1; ppu_addr = 14'h3FFF; #1;
    check("R9 ppu no we", {31'd0, chr_we}, 32'd0);
    ppu_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    board_mirror = 2'd1; ppu_addr = '0; ppu_rd = 1'b0; ppu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_windows();
    t_wrap();
    t_mirror();
    t_outside();
    t_chr();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule